// File: doc/BRIEF.md
# Subtraction Special-Case Resolver

This stage takes the two operands of a reverse subtraction (result = source − destination) in extended-precision layout and decides whether the answer is fixed by the operand classes alone. Each operand is sorted into one of seven classes: zero, denormal, normal, infinity, quiet NaN, signaling NaN or unsupported encoding. When the outcome is fully determined by those classes, the stage produces the final value and the exception flags. When both operands are ordinary non-zero finite values that are not bitwise identical, it leaves the work to the normal add/subtract datapath.

The operand layout is sign in the top bit, then an `EXP_W`-bit biased exponent, then an `MAN_W`-bit significand whose top bit is the explicit integer bit. The significand bit just below it is the quiet bit of a NaN. A side flag marks the source as a value converted from an integer. A 2-bit rounding-mode input controls the sign of exact zero results. Results appear one clock after the input strobe, together with an output strobe.

Top module: `sub_special_resolve`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by one clock. When `valid_o` is low, `special_o`, `invalid_o`, `denorm_o` and `result_o` are all zero. All outputs are zero during reset.
- R2: Classes are decoded as follows, with the exponent in bits [W-2:MAN_W] and the integer bit at MAN_W-1. Zero: exponent 0 and significand 0. Denormal: exponent 0 and significand non-zero. Unsupported: exponent non-zero and integer bit 0. Infinity: exponent all ones and only the integer bit set. NaN: exponent all ones, integer bit 1, lower fraction non-zero. A NaN is quiet when bit MAN_W-2 is 1 and signaling otherwise. Every other encoding is normal.
- R3: If either operand is unsupported, that rule wins over all others. The stage gives special, invalid and the default NaN (sign 1, exponent all ones, top two significand bits 1, rest 0).
- R4: Otherwise, if either operand is a NaN, the result is that NaN with bit MAN_W-2 forced to 1. When both are NaN, the one with the larger unsigned significand is used, and the source wins a tie. `invalid_o` is set only when a NaN operand is signaling.
- R5: Two infinities of the same sign give special, invalid and the default NaN.
- R6: Infinities of opposite sign give the source. A single infinite source gives the source. A single infinite destination gives the destination with its sign inverted.
- R7: Two zeros of the same effective sign give −0 when `rmode_i` is 2'b01 (toward −∞), and +0 for 2'b00, 2'b10 and 2'b11.
- R8: Two zeros of opposite effective sign give the source zero unchanged (+0 − (−0) = +0, −0 − (+0) = −0).
- R9: When `src_int_i` is set and the source is zero, the source is taken as +0 whatever its sign bit.
- R10: A zero source with a non-zero finite destination gives the negated destination. A zero destination with a non-zero finite source gives the source.
- R11: Bitwise identical non-zero finite operands give an exact zero, signed as in R7.
- R12: `denorm_o` is set when the source is denormal and `src_int_i` is low, whatever the result.
- R13: Two non-zero finite operands that are not identical give `special_o` low, `invalid_o` low and `result_o` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| src_i | input | 1+EXP_W+MAN_W | Source operand (minuend) |
| dst_i | input | 1+EXP_W+MAN_W | Destination operand (subtrahend) |
| src_int_i | input | 1 | Source was converted from an integer |
| rmode_i | input | 2 | Rounding mode: 00 nearest, 01 toward −∞, 10 toward +∞, 11 toward zero |
| valid_o | output | 1 | Result strobe, one clock after `valid_i` |
| special_o | output | 1 | Result is fixed by operand classes |
| result_o | output | 1+EXP_W+MAN_W | Special result value, zero when not special |
| invalid_o | output | 1 | Invalid-operation flag |
| denorm_o | output | 1 | Denormal source flag |

## Verification
The only state in this stage is one output register, so a wrong class decode or a wrong priority shows at the ports on the very next clock after the strobe. A fault can appear as a wrong sign on a zero, an unquieted NaN, the wrong NaN chosen, or a flag that is set or missing. The bench sweeps every source encoding of a 10-bit configuration against a set of destinations that covers every class, with the rounding mode and integer flag varied across the sweep. Any decode or priority error therefore shows up within a few thousand vectors.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_DENORM,
    CLS_NORMAL,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN,
    CLS_UNSUP
  } fp_class_e;

  localparam logic [1:0] RM_NEAREST = 2'b00;
  localparam logic [1:0] RM_DOWN    = 2'b01;
  localparam logic [1:0] RM_UP      = 2'b10;
  localparam logic [1:0] RM_ZERO    = 2'b11;

endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
  import fpsr_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] op_i,
  output fp_class_e            cls_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             int_bit;
  logic             quiet_bit;
  logic             frac_nz;
  logic             unused_sign;

  assign exp_f       = op_i[W-2:MAN_W];
  assign man_f       = op_i[MAN_W-1:0];
  assign int_bit     = man_f[MAN_W-1];
  assign quiet_bit   = man_f[MAN_W-2];
  assign frac_nz     = |man_f[MAN_W-2:0];
  assign unused_sign = op_i[W-1];

  always_comb begin
    if (exp_f == '0)       cls_o = (man_f == '0) ? CLS_ZERO : CLS_DENORM;
    else if (!int_bit)     cls_o = CLS_UNSUP;
    else if (&exp_f)       cls_o = !frac_nz ? CLS_INF : (quiet_bit ? CLS_QNAN : CLS_SNAN);
    else                   cls_o = CLS_NORMAL;
  end

endmodule

// File: rtl/fpsr_nan_pick.sv
module fpsr_nan_pick #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] src_i,
  input  logic [EXP_W+MAN_W:0] dst_i,
  input  logic                 src_nan_i,
  input  logic                 dst_nan_i,
  output logic [EXP_W+MAN_W:0] nan_o
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QUIET_MASK = W'(1) << (MAN_W - 2);

  logic take_src;

  // source wins a significand tie
  assign take_src = src_nan_i && (!dst_nan_i || (src_i[MAN_W-1:0] >= dst_i[MAN_W-1:0]));
  assign nan_o    = (take_src ? src_i : dst_i) | QUIET_MASK;

endmodule

// File: rtl/fpsr_resolve_core.sv
module fpsr_resolve_core
  import fpsr_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] src_i,
  input  logic [EXP_W+MAN_W:0] dst_i,
  input  fp_class_e            src_cls_i,
  input  fp_class_e            dst_cls_i,
  input  logic                 round_down_i,
  input  logic [EXP_W+MAN_W:0] nan_i,
  output logic                 special_o,
  output logic                 invalid_o,
  output logic [EXP_W+MAN_W:0] result_o
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] DEFAULT_NAN =
    {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};

  logic src_nan, dst_nan, src_snan, dst_snan;
  logic src_inf, dst_inf, src_zero, dst_zero;
  logic src_sgn, dst_sgn;
  logic [W-1:0] dst_neg;
  logic [W-1:0] exact_zero;

  assign src_snan   = (src_cls_i == CLS_SNAN);
  assign dst_snan   = (dst_cls_i == CLS_SNAN);
  assign src_nan    = src_snan || (src_cls_i == CLS_QNAN);
  assign dst_nan    = dst_snan || (dst_cls_i == CLS_QNAN);
  assign src_inf    = (src_cls_i == CLS_INF);
  assign dst_inf    = (dst_cls_i == CLS_INF);
  assign src_zero   = (src_cls_i == CLS_ZERO);
  assign dst_zero   = (dst_cls_i == CLS_ZERO);
  assign src_sgn    = src_i[W-1];
  assign dst_sgn    = dst_i[W-1];
  assign dst_neg    = {~dst_sgn, dst_i[W-2:0]};
  assign exact_zero = {round_down_i, {(W-1){1'b0}}};

  always_comb begin
    special_o = 1'b1;
    invalid_o = 1'b0;
    result_o  = '0;
    if (src_cls_i == CLS_UNSUP || dst_cls_i == CLS_UNSUP) begin
      invalid_o = 1'b1;
      result_o  = DEFAULT_NAN;
    end else if (src_nan || dst_nan) begin
      invalid_o = src_snan || dst_snan;
      result_o  = nan_i;
    end else if (src_inf && dst_inf) begin
      if (src_sgn == dst_sgn) begin
        invalid_o = 1'b1;
        result_o  = DEFAULT_NAN;
      end else begin
        result_o  = src_i;
      end
    end else if (src_inf) begin
      result_o = src_i;
    end else if (dst_inf) begin
      result_o = dst_neg;
    end else if (src_zero && dst_zero) begin
      result_o = (src_sgn != dst_sgn) ? src_i : exact_zero;
    end else if (src_zero) begin
      result_o = dst_neg;
    end else if (dst_zero) begin
      result_o = src_i;
    end else if (src_i == dst_i) begin
      result_o = exact_zero;
    end else begin
      special_o = 1'b0;
    end
  end

endmodule

// File: rtl/sub_special_resolve.sv
module sub_special_resolve
  import fpsr_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [EXP_W+MAN_W:0] src_i,
  input  logic [EXP_W+MAN_W:0] dst_i,
  input  logic                 src_int_i,
  input  logic [1:0]           rmode_i,
  output logic                 valid_o,
  output logic                 special_o,
  output logic [EXP_W+MAN_W:0] result_o,
  output logic                 invalid_o,
  output logic                 denorm_o
);
  localparam int W      = 1 + EXP_W + MAN_W;
  localparam int N_OPND = 2;

  logic [W-1:0] opnd [N_OPND];
  fp_class_e    cls  [N_OPND];

  assign opnd[0] = src_i;
  assign opnd[1] = dst_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    fpsr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i  (opnd[g]),
      .cls_o (cls[g])
    );
  end

  // converted integer zero is always +0
  logic [W-1:0] src_eff;
  assign src_eff = (src_int_i && cls[0] == CLS_ZERO) ? {1'b0, src_i[W-2:0]} : src_i;

  logic [W-1:0] nan_sel;
  fpsr_nan_pick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nan (
    .src_i     (src_eff),
    .dst_i     (dst_i),
    .src_nan_i (cls[0] == CLS_QNAN || cls[0] == CLS_SNAN),
    .dst_nan_i (cls[1] == CLS_QNAN || cls[1] == CLS_SNAN),
    .nan_o     (nan_sel)
  );

  logic         sp_d, inv_d, dn_d;
  logic [W-1:0] res_d;

  fpsr_resolve_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_core (
    .src_i        (src_eff),
    .dst_i        (dst_i),
    .src_cls_i    (cls[0]),
    .dst_cls_i    (cls[1]),
    .round_down_i (rmode_i == RM_DOWN),
    .nan_i        (nan_sel),
    .special_o    (sp_d),
    .invalid_o    (inv_d),
    .result_o     (res_d)
  );

  assign dn_d = (cls[0] == CLS_DENORM) && !src_int_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      special_o <= 1'b0;
      invalid_o <= 1'b0;
      denorm_o  <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o   <= valid_i;
      special_o <= valid_i && sp_d;
      invalid_o <= valid_i && inv_d;
      denorm_o  <= valid_i && dn_d;
      result_o  <= valid_i ? res_d : '0;
    end
  end

endmodule

// File: rtl/fpsr_chk.sv
module fpsr_chk #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [EXP_W+MAN_W:0] src_i,
  input logic [EXP_W+MAN_W:0] dst_i,
  input logic                 src_int_i,
  input logic [1:0]           rmode_i,
  input logic                 valid_o,
  input logic                 special_o,
  input logic [EXP_W+MAN_W:0] result_o,
  input logic                 invalid_o,
  input logic                 denorm_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic src_zero, dst_zero, src_inf, dst_inf, src_den;
  assign src_zero = (src_i[W-2:0] == '0);
  assign dst_zero = (dst_i[W-2:0] == '0);
  assign src_inf  = (&src_i[W-2:MAN_W]) && (src_i[MAN_W-1:0] == (MAN_W'(1) << (MAN_W-1)));
  assign dst_inf  = (&dst_i[W-2:MAN_W]) && (dst_i[MAN_W-1:0] == (MAN_W'(1) << (MAN_W-1)));
  assign src_den  = (src_i[W-2:MAN_W] == '0) && (src_i[MAN_W-1:0] != '0);

  // R1
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (valid_o == $past(valid_i)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!special_o && !invalid_o && !denorm_o && result_o == '0));

  // R3
  invalid_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (special_o && (&result_o[W-2:MAN_W]) && result_o[MAN_W-2]));

  // R5
  like_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src_inf && dst_inf && src_i[W-1] == dst_i[W-1]) |=> invalid_o);

  // R7
  zero_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !src_int_i && src_zero && dst_zero && src_i[W-1] == dst_i[W-1] && rmode_i == 2'b01)
      |=> (result_o == {1'b1, {(W-1){1'b0}}}));

  // R8
  unlike_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !src_int_i && src_zero && dst_zero && src_i[W-1] != dst_i[W-1])
      |=> (result_o == $past(src_i)));

  // R12
  denorm_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !src_int_i && src_den) |=> denorm_o);

endmodule

bind sub_special_resolve fpsr_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .src_i     (src_i),
  .dst_i     (dst_i),
  .src_int_i (src_int_i),
  .rmode_i   (rmode_i),
  .valid_o   (valid_o),
  .special_o (special_o),
  .result_o  (result_o),
  .invalid_o (invalid_o),
  .denorm_o  (denorm_o)
);

// File: tb/sim_sub_special_resolve.sv
module sim_sub_special_resolve;
  localparam int EW = 4;
  localparam int MW = 5;
  localparam int W  = 1 + EW + MW;
  localparam int ND = 24;
  localparam logic [W-1:0] INDEF = {1'b1, 4'hF, 5'b11000};

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] src_i = '0;
  logic [W-1:0] dst_i = '0;
  logic         src_int_i = 1'b0;
  logic [1:0]   rmode_i = 2'b00;
  logic         valid_o, special_o, invalid_o, denorm_o;
  logic [W-1:0] result_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk_i = ~clk_i;

  sub_special_resolve #(.EXP_W(EW), .MAN_W(MW)) u0 (
    .clk_i, .rst_ni, .valid_i, .src_i, .dst_i, .src_int_i, .rmode_i,
    .valid_o, .special_o, .result_o, .invalid_o, .denorm_o
  );

  function automatic logic [EW-1:0] ex(input logic [W-1:0] x); return x[W-2:MW]; endfunction
  function automatic logic [MW-1:0] mn(input logic [W-1:0] x); return x[MW-1:0]; endfunction
  function automatic logic is_zero(input logic [W-1:0] x); return ex(x) == 0 && mn(x) == 0; endfunction
  function automatic logic is_den(input logic [W-1:0] x);  return ex(x) == 0 && mn(x) != 0; endfunction
  function automatic logic is_uns(input logic [W-1:0] x);  return ex(x) != 0 && !x[MW-1]; endfunction
  function automatic logic is_inf(input logic [W-1:0] x);  return ex(x) == 4'hF && mn(x) == 5'b10000; endfunction
  function automatic logic is_nan(input logic [W-1:0] x);  return ex(x) == 4'hF && x[MW-1] && x[MW-2:0] != 0; endfunction
  function automatic logic is_snan(input logic [W-1:0] x); return is_nan(x) && !x[MW-2]; endfunction

  task automatic ref_model(input logic [W-1:0] s, input logic [W-1:0] d, input logic si,
                           input logic [1:0] rm, output logic sp, output logic inv,
                           output logic dn, output logic [W-1:0] r, output string tag);
    logic [W-1:0] se;
    sp = 1'b1; inv = 1'b0; r = '0; tag = "R13";
    dn = is_den(s) && !si;
    se = (si && is_zero(s)) ? {1'b0, s[W-2:0]} : s;
    if (is_uns(s) || is_uns(d)) begin
      inv = 1'b1; r = INDEF; tag = "R3";
    end else if (is_nan(s) || is_nan(d)) begin
      inv = is_snan(s) || is_snan(d); tag = "R4";
      r = (is_nan(s) && (!is_nan(d) || mn(s) >= mn(d))) ? s : d;
      r[MW-2] = 1'b1;
    end else if (is_inf(s) && is_inf(d)) begin
      if (s[W-1] == d[W-1]) begin inv = 1'b1; r = INDEF; tag = "R5"; end
      else begin r = s; tag = "R6"; end
    end else if (is_inf(s)) begin
      r = s; tag = "R6";
    end else if (is_inf(d)) begin
      r = {~d[W-1], d[W-2:0]}; tag = "R6";
    end else if (is_zero(s) && is_zero(d)) begin
      if (se[W-1] != d[W-1]) begin r = se; tag = si ? "R9" : "R8"; end
      else begin r = {rm == 2'b01, {(W-1){1'b0}}}; tag = si ? "R9" : "R7"; end
    end else if (is_zero(s)) begin
      r = {~d[W-1], d[W-2:0]}; tag = "R10";
    end else if (is_zero(d)) begin
      r = s; tag = "R10";
    end else if (s == d) begin
      r = {rm == 2'b01, {(W-1){1'b0}}}; tag = "R11";
    end else begin
      sp = 1'b0;
    end
  endtask

  logic [W-1:0] dl [ND];
  initial begin
    dl[0]  = {1'b0, 4'h0, 5'b00000}; dl[1]  = {1'b1, 4'h0, 5'b00000};
    dl[2]  = {1'b0, 4'h0, 5'b00011}; dl[3]  = {1'b1, 4'h0, 5'b11111};
    dl[4]  = {1'b0, 4'h7, 5'b10000}; dl[5]  = {1'b1, 4'h7, 5'b10000};
    dl[6]  = {1'b0, 4'h3, 5'b10110}; dl[7]  = {1'b0, 4'hE, 5'b11111};
    dl[8]  = {1'b0, 4'hF, 5'b10000}; dl[9]  = {1'b1, 4'hF, 5'b10000};
    dl[10] = {1'b0, 4'hF, 5'b11000}; dl[11] = {1'b0, 4'hF, 5'b11011};
    dl[12] = {1'b1, 4'hF, 5'b11100}; dl[13] = {1'b0, 4'hF, 5'b10010};
    dl[14] = {1'b1, 4'hF, 5'b10111}; dl[15] = {1'b0, 4'h5, 5'b01000};
    dl[16] = {1'b0, 4'hF, 5'b00000}; dl[17] = {1'b1, 4'hF, 5'b01100};
    dl[18] = {1'b0, 4'h1, 5'b10000}; dl[19] = {1'b1, 4'h1, 5'b10000};
    dl[20] = {1'b1, 4'h0, 5'b10001}; dl[21] = {1'b1, 4'hF, 5'b11111};
    dl[22] = {1'b0, 4'hF, 5'b10001}; dl[23] = {1'b1, 4'h9, 5'b10101};
  end

  task automatic check(input string tag, input logic ok, input logic [W+3:0] act,
                       input logic [W+3:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (R2 classes): actual %h expected %h", tag, act, exp_v);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic sp, inv, dn;
    logic [W-1:0] r;
    string tag;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", {valid_o, special_o, invalid_o, denorm_o, result_o} == '0,
          {valid_o, special_o, invalid_o, denorm_o, result_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int s = 0; s < (1 << W); s++) begin
      for (int k = 0; k < ND; k++) begin
        src_i     = W'(s);
        dst_i     = dl[k];
        rmode_i   = 2'((s + k) % 4);
        src_int_i = 1'((s >> 1) ^ k);
        valid_i   = 1'b1;
        ref_model(src_i, dst_i, src_int_i, rmode_i, sp, inv, dn, r, tag);
        @(negedge clk_i);
        check(tag, {valid_o, special_o, invalid_o, result_o} == {1'b1, sp, inv, r},
              {1'b0, valid_o, special_o, invalid_o, result_o}, {1'b0, 1'b1, sp, inv, r});
        check("R12", denorm_o == dn, {{(W+3){1'b0}}, denorm_o}, {{(W+3){1'b0}}, dn});
      end
    end
    // R1: bubble with a special-looking operand pair
    valid_i = 1'b0;
    src_i = dl[8]; dst_i = dl[8]; src_int_i = 1'b0; rmode_i = 2'b01;
    @(negedge clk_i);
    check("R1", {valid_o, special_o, invalid_o, denorm_o, result_o} == '0,
          {valid_o, special_o, invalid_o, denorm_o, result_o}, '0);
    src_i = dl[2];
    @(negedge clk_i);
    check("R1", {valid_o, denorm_o} == 2'b00, {{(W+2){1'b0}}, valid_o, denorm_o}, '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule